// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory Entry

This block holds and maintains the coherence directory record of a single memory block at its home node. The record keeps one flag for the home node's own cache and a fixed number of pointer slots. Each slot has a valid bit and names one remote node that holds a clean copy. A dirty flag marks a block owned for writing by exactly one holder. An overflow flag records that more remote sharers exist than the slots can name. Requests arrive one at a time, each carrying a node id and one of three operations: a read miss, a write request, or a notice that a clean copy was replaced.

When a write arrives, every recorded holder other than the writer must be invalidated. The block produces these invalidate commands one node id per handshake on a valid/ready output. It accepts no new request until the last command has been taken. Then it rewrites the record so that only the writer remains. A parameter picks the overflow policy. In broadcast mode, a read that finds every slot taken sets the overflow flag, and the next write invalidates every node. In no-broadcast mode, the same read forces an invalidation of the sharer in slot 0, and that slot is then handed to the new reader. The current record is visible on output ports.

Top module: `dir_entry_mgr`

## Requirements
- R1: After reset the record is empty (no slot valid, home flag, overflow and dirty all 0), `req_ready` is 1 and `inv_valid` is 0.
- R2: A read from a remote node not yet recorded stores its id in the lowest-numbered slot whose valid bit is 0 and sets that valid bit. Any read clears the dirty flag.
- R3: A read from a remote node already named by a valid slot leaves the slots unchanged, so no node ever appears in two valid slots.
- R4: A request whose node id equals the home node id (parameter `HOME_NODE`, default 0) never touches a slot. A read sets the home flag, a replace notice clears it, and a write leaves only the home flag set.
- R5: A replace notice (op 2) from a remote node clears the valid bit of the slot naming it, and that slot is reused by later reads. A replace notice for a node that is not recorded changes no slot. Every replace notice clears the dirty flag.
- R6: In broadcast mode (`BCAST`=1), a read from an unrecorded remote node while all slots are valid sets the overflow flag, leaves the slots unchanged and issues no invalidate.
- R7: In no-broadcast mode (`BCAST`=0), the same read issues one invalidate to the node in slot 0 and then writes the reader's id into slot 0. The overflow flag is never set.
- R8: A write (op 1) without overflow issues one invalidate to each node named by a valid slot, and to the home node if the home flag is set, excluding the writer. Afterwards the writer is the only holder (slot 0 for a remote writer), dirty is 1 and overflow is 0.
- R9: A write while the overflow flag is set issues one invalidate to every node id from 0 to 2^`NODE_W`-1 except the writer, then leaves the record as in R8.
- R10: Invalidates are issued in ascending node-id order, one per cycle with `inv_valid` and `inv_ready` both high. `inv_node` holds steady while `inv_ready` is low, and `req_ready` stays 0 while any invalidate is pending.

Read is op 0, write is op 1 and replace is op 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 read, 1 write, 2 clean replace |
| req_node | input | NODE_W | Requesting node id |
| req_ready | output | 1 | Request taken on this edge when high with req_valid |
| inv_valid | output | 1 | Invalidate command present |
| inv_node | output | NODE_W | Node to invalidate |
| inv_ready | input | 1 | Invalidate command taken |
| ent_local | output | 1 | Home cache holds a copy |
| ent_vld | output | N_PTR | Slot valid bits, bit k for slot k |
| ent_ptr | output | N_PTR*NODE_W | Slot k node id at bits k*NODE_W upward |
| ent_ovf | output | 1 | More remote sharers than slots |
| ent_dirty | output | 1 | Single holder has write ownership |

## Verification
Reads and replace notices that need no invalidate update the record at the edge that accepts them, so the bench reads the record on the next falling edge. A write or forced eviction raises `inv_valid` one cycle after acceptance and advances one node per ready edge. The final record and `req_ready` change at the same edge that takes the last invalidate. The bench drives each request on a falling edge, records each command on the falling edge before its handshake edge, and compares the record only once `req_ready` is seen high again. One eviction holds `inv_ready` low for three cycles and checks that the pending command stays put.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_RPL = 2'd2
  } dir_op_e;
endpackage

// File: rtl/dir_slot_match.sv
// Finds the slot naming a node and the lowest free slot.
module dir_slot_match #(
  parameter int NODE_W = 4,
  parameter int N_PTR  = 4,
  localparam int IDX_W = (N_PTR > 1) ? $clog2(N_PTR) : 1
) (
  input  logic [N_PTR-1:0]        vld,
  input  logic [N_PTR*NODE_W-1:0] ptr,
  input  logic [NODE_W-1:0]       node,
  output logic                    hit,
  output logic [N_PTR-1:0]        hit_oh,
  output logic                    full,
  output logic [IDX_W-1:0]        free_idx
);
  for (genvar k = 0; k < N_PTR; k++) begin : g_cmp
    assign hit_oh[k] = vld[k] && (ptr[k*NODE_W +: NODE_W] == node);
  end

  assign hit  = |hit_oh;
  assign full = &vld;

  always_comb begin
    free_idx = '0;
    for (int k = N_PTR - 1; k >= 0; k--) begin
      if (!vld[k]) free_idx = IDX_W'(k);
    end
  end
endmodule

// File: rtl/dir_target_gen.sv
// Builds the per-node set of invalidate targets.
module dir_target_gen #(
  parameter int NODE_W    = 4,
  parameter int N_PTR     = 4,
  parameter int HOME_NODE = 0,
  localparam int N_NODES  = 1 << NODE_W
) (
  input  logic [N_PTR-1:0]        vld,
  input  logic [N_PTR*NODE_W-1:0] ptr,
  input  logic                    local_cp,
  input  logic                    ovf,
  input  logic                    evict,
  input  logic [NODE_W-1:0]       writer,
  output logic [N_NODES-1:0]      targets
);
  localparam logic [N_NODES-1:0] ONE = {{(N_NODES-1){1'b0}}, 1'b1};

  logic [N_NODES-1:0] raw;

  always_comb begin
    raw = '0;
    if (evict) begin
      raw = ONE << ptr[NODE_W-1:0];
    end else if (ovf) begin
      raw = '1;
    end else begin
      for (int k = 0; k < N_PTR; k++) begin
        if (vld[k]) raw = raw | (ONE << ptr[k*NODE_W +: NODE_W]);
      end
      if (local_cp) raw[HOME_NODE] = 1'b1;
    end
    targets = raw & ~(ONE << writer);
  end
endmodule

// File: rtl/dir_pick_lowest.sv
// Priority encoder: index of the lowest set bit.
module dir_pick_lowest #(
  parameter int N      = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (vec[k]) idx = IDX_W'(k);
    end
  end
endmodule

// File: rtl/dir_entry_mgr.sv
module dir_entry_mgr
  import dir_pkg::*;
#(
  parameter int NODE_W    = 4,
  parameter int N_PTR     = 4,
  parameter int HOME_NODE = 0,
  parameter bit BCAST     = 1'b1,
  localparam int N_NODES  = 1 << NODE_W,
  localparam int IDX_W    = (N_PTR > 1) ? $clog2(N_PTR) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [1:0]              req_op,
  input  logic [NODE_W-1:0]       req_node,
  output logic                    req_ready,
  output logic                    inv_valid,
  output logic [NODE_W-1:0]       inv_node,
  input  logic                    inv_ready,
  output logic                    ent_local,
  output logic [N_PTR-1:0]        ent_vld,
  output logic [N_PTR*NODE_W-1:0] ent_ptr,
  output logic                    ent_ovf,
  output logic                    ent_dirty
);
  localparam logic [N_NODES-1:0] ONE  = {{(N_NODES-1){1'b0}}, 1'b1};
  localparam logic [NODE_W-1:0]  HOME = NODE_W'(HOME_NODE);

  // record state
  logic                loc_q, ovf_q, dirty_q;
  logic [N_PTR-1:0]    vld_q;
  logic [NODE_W-1:0]   ptr_q [N_PTR];
  logic [N_PTR*NODE_W-1:0] ptr_flat;

  // invalidate sequencing state
  logic                busy_q;
  logic [N_NODES-1:0]  pend_q;
  dir_op_e             op_q;
  logic [NODE_W-1:0]   node_q;

  for (genvar k = 0; k < N_PTR; k++) begin : g_flat
    assign ptr_flat[k*NODE_W +: NODE_W] = ptr_q[k];
  end

  dir_op_e op_in;
  assign op_in = dir_op_e'(req_op);

  logic             hit, full;
  logic [N_PTR-1:0] hit_oh;
  logic [IDX_W-1:0] free_idx;

  dir_slot_match #(.NODE_W(NODE_W), .N_PTR(N_PTR)) u_match (
    .vld(vld_q), .ptr(ptr_flat), .node(req_node),
    .hit(hit), .hit_oh(hit_oh), .full(full), .free_idx(free_idx)
  );

  logic [N_NODES-1:0] targets;

  dir_target_gen #(.NODE_W(NODE_W), .N_PTR(N_PTR), .HOME_NODE(HOME_NODE)) u_tgt (
    .vld(vld_q), .ptr(ptr_flat), .local_cp(loc_q), .ovf(ovf_q),
    .evict(op_in == OP_RD), .writer(req_node), .targets(targets)
  );

  logic              pend_any;
  logic [NODE_W-1:0] pend_idx;

  dir_pick_lowest #(.N(N_NODES)) u_pick (
    .vec(pend_q), .any(pend_any), .idx(pend_idx)
  );

  // control decode
  logic               acc, is_home, last, do_wr, do_ev, rd_evict;
  logic [N_NODES-1:0] inv_oh;
  logic [NODE_W-1:0]  wr_node;

  assign acc      = !busy_q && req_valid;
  assign is_home  = (req_node == HOME);
  assign inv_oh   = ONE << pend_idx;
  assign last     = busy_q && inv_ready && ((pend_q & ~inv_oh) == '0);
  assign rd_evict = !BCAST && !is_home && !hit && full;
  assign do_wr    = (acc && op_in == OP_WR && targets == '0) ||
                    (last && op_q == OP_WR);
  assign do_ev    = last && op_q == OP_RD;
  assign wr_node  = busy_q ? node_q : req_node;

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_q   <= 1'b0;
      ovf_q   <= 1'b0;
      dirty_q <= 1'b0;
      vld_q   <= '0;
      for (int k = 0; k < N_PTR; k++) ptr_q[k] <= '0;
      busy_q  <= 1'b0;
      pend_q  <= '0;
      op_q    <= OP_RD;
      node_q  <= '0;
    end else begin
      if (acc) begin
        unique case (op_in)
          OP_RD: begin
            dirty_q <= 1'b0;
            if (is_home) begin
              loc_q <= 1'b1;
            end else if (!hit) begin
              if (!full) begin
                ptr_q[free_idx] <= req_node;
                vld_q[free_idx] <= 1'b1;
              end else if (BCAST) begin
                ovf_q <= 1'b1;
              end
            end
            if (rd_evict) begin
              pend_q <= targets;
              busy_q <= 1'b1;
              op_q   <= OP_RD;
              node_q <= req_node;
            end
          end
          OP_WR: begin
            if (targets != '0) begin
              pend_q <= targets;
              busy_q <= 1'b1;
              op_q   <= OP_WR;
              node_q <= req_node;
            end
          end
          OP_RPL: begin
            dirty_q <= 1'b0;
            if (is_home) loc_q <= 1'b0;
            else         vld_q <= vld_q & ~hit_oh;
          end
          default: ;
        endcase
      end

      if (busy_q && inv_ready) pend_q <= pend_q & ~inv_oh;
      if (last) busy_q <= 1'b0;

      if (do_wr) begin
        vld_q   <= '0;
        ovf_q   <= 1'b0;
        dirty_q <= 1'b1;
        if (wr_node == HOME) begin
          loc_q <= 1'b1;
        end else begin
          loc_q    <= 1'b0;
          vld_q[0] <= 1'b1;
          ptr_q[0] <= wr_node;
        end
      end

      if (do_ev) ptr_q[0] <= node_q;
    end
  end

  assign req_ready = !busy_q;
  assign inv_valid = busy_q && pend_any;
  assign inv_node  = pend_idx;
  assign ent_local = loc_q;
  assign ent_vld   = vld_q;
  assign ent_ptr   = ptr_flat;
  assign ent_ovf   = ovf_q;
  assign ent_dirty = dirty_q;
endmodule

// File: rtl/dir_entry_chk.sv
module dir_entry_chk #(
  parameter int NODE_W = 4,
  parameter int N_PTR  = 4,
  parameter bit BCAST  = 1'b1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_ready,
  input logic                    inv_valid,
  input logic                    inv_ready,
  input logic [NODE_W-1:0]       inv_node,
  input logic                    ent_local,
  input logic [N_PTR-1:0]        ent_vld,
  input logic [N_PTR*NODE_W-1:0] ent_ptr,
  input logic                    ent_ovf,
  input logic                    ent_dirty
);
  // R1: reset empties the record and idles the command output
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!inv_valid && req_ready && ent_vld == '0 && !ent_local && !ent_ovf && !ent_dirty));

  // R10: a stalled command is held
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_node)));

  // R10: no request accepted while commands are pending
  p_busy_r10: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> !req_ready);

  // R10: commands leave in ascending node order
  p_order_r10: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && inv_ready) |=> (!inv_valid || inv_node > $past(inv_node)));

  // R6: overflow only rises when every slot is in use
  p_ovf_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ent_ovf) |-> (&ent_vld));

  // R8: a dirty block has exactly one holder
  p_dirty_single_r8: assert property (@(posedge clk) disable iff (rst)
    ent_dirty |-> ($countones({ent_vld, ent_local}) == 1));

  if (!BCAST) begin : g_nb
    // R7: overflow is never used without broadcast
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst) !ent_ovf);
  end

  // R3: no node named twice
  for (genvar a = 0; a < N_PTR; a++) begin : g_a
    for (genvar b = a + 1; b < N_PTR; b++) begin : g_b
      p_nodup_r3: assert property (@(posedge clk) disable iff (rst)
        !(ent_vld[a] && ent_vld[b] &&
          ent_ptr[a*NODE_W +: NODE_W] == ent_ptr[b*NODE_W +: NODE_W]));
    end
  end
endmodule

bind dir_entry_mgr dir_entry_chk #(.NODE_W(NODE_W), .N_PTR(N_PTR), .BCAST(BCAST)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .inv_valid(inv_valid),
  .inv_ready(inv_ready), .inv_node(inv_node), .ent_local(ent_local),
  .ent_vld(ent_vld), .ent_ptr(ent_ptr), .ent_ovf(ent_ovf), .ent_dirty(ent_dirty)
);

// File: tb/dir_entry_mgr_tb.sv
`timescale 1ns/1ps
module dir_entry_mgr_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic       sel = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [3:0] req_node = 4'd0;
  logic       inv_ready = 1'b1;

  // broadcast instance: 4 slots; no-broadcast instance: 2 slots
  logic a_ready, a_iv, a_loc, a_ovf, a_dirty;
  logic [3:0] a_in, a_vld;
  logic [15:0] a_ptr;
  logic b_ready, b_iv, b_loc, b_ovf, b_dirty;
  logic [3:0] b_in;
  logic [1:0] b_vld;
  logic [7:0] b_ptr;

  dir_entry_mgr #(.NODE_W(4), .N_PTR(4), .HOME_NODE(0), .BCAST(1'b1)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid && !sel), .req_op(req_op),
    .req_node(req_node), .req_ready(a_ready), .inv_valid(a_iv), .inv_node(a_in),
    .inv_ready(inv_ready), .ent_local(a_loc), .ent_vld(a_vld), .ent_ptr(a_ptr),
    .ent_ovf(a_ovf), .ent_dirty(a_dirty)
  );

  dir_entry_mgr #(.NODE_W(4), .N_PTR(2), .HOME_NODE(0), .BCAST(1'b0)) u_dut_nb (
    .clk(clk), .rst(rst), .req_valid(req_valid && sel), .req_op(req_op),
    .req_node(req_node), .req_ready(b_ready), .inv_valid(b_iv), .inv_node(b_in),
    .inv_ready(inv_ready), .ent_local(b_loc), .ent_vld(b_vld), .ent_ptr(b_ptr),
    .ent_ovf(b_ovf), .ent_dirty(b_dirty)
  );

  logic o_ready, o_iv, o_loc, o_ovf, o_dirty;
  logic [3:0] o_in, o_vld;
  logic [15:0] o_ptr;
  always_comb begin
    o_ready = sel ? b_ready : a_ready;
    o_iv    = sel ? b_iv    : a_iv;
    o_in    = sel ? b_in    : a_in;
    o_loc   = sel ? b_loc   : a_loc;
    o_ovf   = sel ? b_ovf   : a_ovf;
    o_dirty = sel ? b_dirty : a_dirty;
    o_vld   = sel ? {2'b00, b_vld} : a_vld;
    o_ptr   = sel ? {8'h00, b_ptr} : a_ptr;
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mask_ptr(input logic [3:0] v, input logic [15:0] p);
    logic [15:0] r;
    for (int s = 0; s < 4; s++) r[s*4 +: 4] = v[s] ? p[s*4 +: 4] : 4'h0;
    return r;
  endfunction

  // record snapshot: {vld, masked ptr, local, ovf, dirty}
  function automatic logic [22:0] snap();
    return {o_vld, mask_ptr(o_vld, o_ptr), o_loc, o_ovf, o_dirty};
  endfunction

  task automatic run_req(input logic s, input logic [1:0] op, input logic [3:0] nd,
                         input bit stall, output logic [15:0] invm);
    logic [3:0] prev, held;
    bit first;
    int guard;
    invm = '0; first = 1'b1; prev = '0; guard = 0;
    @(negedge clk);
    sel = s; req_op = op; req_node = nd; req_valid = 1'b1;
    if (stall) inv_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    if (stall) begin
      held = o_in;
      for (int k = 0; k < 3; k++) begin
        chk(o_iv && !o_ready && o_in == held, "R10 stall hold",
            {o_iv, o_ready, o_in}, {1'b1, 1'b0, held});
        @(negedge clk);
      end
      inv_ready = 1'b1;
    end
    while (!o_ready && guard < 200) begin
      if (o_iv && inv_ready) begin
        if (!first) chk(o_in > prev, "R10 ascending order", o_in, prev + 4'd1);
        invm[o_in] = 1'b1;
        prev = o_in;
        first = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
  endtask

  typedef struct packed {
    logic [3:0]  rq;
    logic [1:0]  op;
    logic [3:0]  node;
    logic [3:0]  vld;
    logic [15:0] ptr;
    logic        loc;
    logic        ovf;
    logic        dirty;
    logic [15:0] inv;
  } vec_t;

  // Broadcast instance sequence; home node is 0, ops: 0 read, 1 write, 2 replace
  localparam vec_t TBL [16] = '{
    '{4'd2, 2'd0, 4'd3,  4'b0001, 16'h0003, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2
    '{4'd2, 2'd0, 4'd5,  4'b0011, 16'h0053, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2
    '{4'd3, 2'd0, 4'd3,  4'b0011, 16'h0053, 1'b0, 1'b0, 1'b0, 16'h0000}, // R3
    '{4'd4, 2'd0, 4'd0,  4'b0011, 16'h0053, 1'b1, 1'b0, 1'b0, 16'h0000}, // R4
    '{4'd5, 2'd2, 4'd3,  4'b0010, 16'h0050, 1'b1, 1'b0, 1'b0, 16'h0000}, // R5
    '{4'd5, 2'd0, 4'd7,  4'b0011, 16'h0057, 1'b1, 1'b0, 1'b0, 16'h0000}, // R5 reuse
    '{4'd2, 2'd0, 4'd9,  4'b0111, 16'h0957, 1'b1, 1'b0, 1'b0, 16'h0000}, // R2
    '{4'd2, 2'd0, 4'd10, 4'b1111, 16'hA957, 1'b1, 1'b0, 1'b0, 16'h0000}, // R2
    '{4'd6, 2'd0, 4'd12, 4'b1111, 16'hA957, 1'b1, 1'b1, 1'b0, 16'h0000}, // R6
    '{4'd9, 2'd1, 4'd5,  4'b0001, 16'h0005, 1'b0, 1'b0, 1'b1, 16'hFFDF}, // R9
    '{4'd2, 2'd0, 4'd3,  4'b0011, 16'h0035, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2
    '{4'd8, 2'd1, 4'd3,  4'b0001, 16'h0003, 1'b0, 1'b0, 1'b1, 16'h0020}, // R8
    '{4'd4, 2'd0, 4'd0,  4'b0001, 16'h0003, 1'b1, 1'b0, 1'b0, 16'h0000}, // R4
    '{4'd8, 2'd1, 4'd0,  4'b0000, 16'h0000, 1'b1, 1'b0, 1'b1, 16'h0008}, // R8 home writer
    '{4'd4, 2'd2, 4'd0,  4'b0000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000}, // R4
    '{4'd5, 2'd2, 4'd6,  4'b0000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000}  // R5 absent
  };

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R10 actual=%0d expected<100000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] im;
    logic [22:0] exp_s;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state on both instances
    chk(a_ready && !a_iv && a_vld == 0 && !a_loc && !a_ovf && !a_dirty, "R1 reset bcast",
        {a_ready, a_iv, a_vld, a_loc, a_ovf, a_dirty}, 9'b1_0_0000_000);
    chk(b_ready && !b_iv && b_vld == 0 && !b_loc && !b_ovf && !b_dirty, "R1 reset nb",
        {b_ready, b_iv, b_vld, b_loc, b_ovf, b_dirty}, 7'b1_0_00_000);

    for (int r = 0; r < 16; r++) begin
      run_req(1'b0, TBL[r].op, TBL[r].node, 1'b0, im);
      exp_s = {TBL[r].vld, TBL[r].ptr, TBL[r].loc, TBL[r].ovf, TBL[r].dirty};
      chk(snap() == exp_s, $sformatf("R%0d row %0d record", TBL[r].rq, r), snap(), exp_s);
      chk(im == TBL[r].inv, $sformatf("R%0d row %0d invalidates", TBL[r].rq, r), im, TBL[r].inv);
    end

    // R7: no-broadcast eviction of slot 0, with a stalled command (R10)
    run_req(1'b1, 2'd0, 4'd1, 1'b0, im);
    run_req(1'b1, 2'd0, 4'd2, 1'b0, im);
    chk(snap() == {4'b0011, 16'h0021, 3'b000}, "R2 nb fill", snap(), {4'b0011, 16'h0021, 3'b000});
    run_req(1'b1, 2'd0, 4'd4, 1'b1, im);
    chk(im == 16'h0002, "R7 evict target", im, 16'h0002);
    chk(snap() == {4'b0011, 16'h0024, 3'b000}, "R7 slot0 replaced", snap(), {4'b0011, 16'h0024, 3'b000});
    run_req(1'b1, 2'd1, 4'd2, 1'b0, im);
    chk(im == 16'h0010, "R8 nb write targets", im, 16'h0010);
    chk(snap() == {4'b0001, 16'h0002, 3'b001}, "R8 nb write record", snap(), {4'b0001, 16'h0002, 3'b001});

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule